// File: doc/BRIEF.md
# BCD Calendar Counter Chain

This block keeps wall-clock time and the calendar date as a ripple of packed-BCD counters. A one-millisecond tick enters at the bottom digit, and each stage passes its carry to the next one up: milliseconds, hundredths of a second, seconds, minutes, hours, day of month, month and year. A day-of-week counter advances alongside the day of month. A 2-bit leap-phase counter advances on every year wrap, and February gets a 29th day only when that counter is zero.

A host sets any field through a per-field load strobe and a shared data byte. A level input selects the hour format, either 24-hour or 12-hour with a PM flag. The counters advance only while the run enable is high and the oscillator-fail flag is low. For each fine time boundary the block raises a registered one-cycle rollover pulse, which neighbouring logic can use to build periodic events.

Top module: `rtc_bcd_chain`

## Requirements
- R1: A tick advances nothing unless `run_i` is 1 and `osc_fail_i` is 0. When the tick is blocked, every field and `roll_o` stay unchanged or at zero.
- R2: The millisecond digit counts 0 to 9. Its wrap steps hundredths, which counts 00 to 99 in BCD, and the hundredths wrap steps seconds.
- R3: Seconds and minutes each count 00 to 59 in BCD. A seconds wrap steps minutes, and a minutes wrap steps the hour.
- R4: With `hour12_i`=0 the hour counts 00 to 23 in BCD. The 23 to 00 wrap steps the day.
- R5: With `hour12_i`=1, hour bits [4:0] hold BCD 01..12 and bit 5 is the PM flag. Stepping from 12 gives 01 and inverts the PM flag. The day is stepped only when that inversion clears the flag (PM 12 to AM 01).
- R6: Day of week counts 1 to 7 and steps once on each day carry.
- R7: The day of month counts from 01 up to a limit and then wraps to 01 and steps the month (01..12). The limit is 30 for months 04, 06, 09 and 11, and 31 for the other valid months. For month 02 it is 29 when the leap phase is 0 and 28 otherwise. Any month value outside 01..12 uses a limit of 31.
- R8: The year counts 00 to 99 in BCD. A year wrap increments the 2-bit leap phase modulo 4.
- R9: `roll_o` is registered and high for one cycle, in the cycle after the tick that caused it. Bit 0 marks each accepted tick (1 ms), bit 1 the millisecond wrap (10 ms), bit 2 a hundredths tens carry (100 ms), bit 3 the hundredths wrap (1 s), bit 4 a seconds tens carry (10 s), and bit 5 the seconds wrap (1 min).
- R10: `ld_i` bit k writes `ld_data_i` into field k on the next clock. The field indices are 0 ms, 1 hundredths, 2 seconds, 3 minutes, 4 hour, 5 day, 6 month, 7 year, 8 day of week, and 9 leap phase (data bits [1:0]). In any cycle with a load, the tick has no effect on any field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle 1 ms tick |
| run_i | input | 1 | Clock-run enable |
| osc_fail_i | input | 1 | Oscillator-fail flag, blocks ticks |
| hour12_i | input | 1 | 1 selects 12-hour format |
| ld_i | input | 10 | Per-field load strobes |
| ld_data_i | input | 8 | Load data byte |
| ms_o | output | 4 | Millisecond BCD digit |
| hund_o | output | 8 | Hundredths, BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour, BCD (bit 5 PM in 12-hour mode) |
| day_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| dow_o | output | 8 | Day of week, 1..7 |
| leap_o | output | 2 | Leap phase counter |
| roll_o | output | 6 | Registered rollover pulses |

## Verification
The hardest states to reach are the long carries: a tick that ripples through every stage into the month, year and leap phase. From reset these need millions of ticks. The bench instead uses the load strobes to preset every lower field to its last value, and then one tick carries all the way through. This is how it reaches the February limit under each leap phase, a month value outside the valid range, the 12-hour PM flip, and the year wrap.

// File: rtl/rtc_chain_pkg.sv
package rtc_chain_pkg;
   localparam int FW       = 8;
   localparam int NFIELDS  = 10;
   localparam int ROLL_W   = 6;

   localparam int F_MS    = 0;
   localparam int F_HUND  = 1;
   localparam int F_SEC   = 2;
   localparam int F_MIN   = 3;
   localparam int F_HOUR  = 4;
   localparam int F_DAY   = 5;
   localparam int F_MONTH = 6;
   localparam int F_YEAR  = 7;
   localparam int F_DOW   = 8;
   localparam int F_LEAP  = 9;

   // packed-BCD increment without range limit
   function automatic logic [FW-1:0] bcd_inc(input logic [FW-1:0] v);
      if (v[3:0] >= 4'd9) return {v[FW-1:4] + 4'd1, 4'h0};
      return v + 1'b1;
   endfunction
endpackage

// File: rtl/rtc_bcd_ctr.sv
module rtc_bcd_ctr
   import rtc_chain_pkg::*;
#(
   parameter int          W       = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic [W-1:0] lo_i,
   input  logic [W-1:0] hi_i,
   output logic [W-1:0] val_o,
   output logic         wrap_o
);
   logic [W-1:0] val_q, nxt_c;
   logic         at_hi;

   initial assert (W == 4 || W == 8) else $error("rtc_bcd_ctr: W must be 4 or 8");

   assign at_hi = (val_q == hi_i);

   generate
      if (W == 4) begin : g_digit
         always_comb nxt_c = at_hi ? lo_i : val_q + 1'b1;
      end else begin : g_pair
         always_comb nxt_c = at_hi ? lo_i : bcd_inc(val_q);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       val_q <= RST_VAL;
      else if (load_i)  val_q <= load_val_i;
      else if (step_i)  val_q <= nxt_c;
   end

   assign val_o  = val_q;
   assign wrap_o = step_i & at_hi;

   // R10: a load always lands
   a_r10_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> val_q == $past(load_val_i));
   // R2 / R3 / R7: stepping at the upper bound returns to the lower bound
   a_r2_wrap_to_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && at_hi) |=> val_q == $past(lo_i));
   a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !load_i) |=> $stable(val_q));
endmodule

// File: rtl/rtc_hour_ctr.sv
module rtc_hour_ctr
   import rtc_chain_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_i,
   input  logic          load_i,
   input  logic [FW-1:0] load_val_i,
   input  logic          mode12_i,
   output logic [FW-1:0] val_o,
   output logic          carry_o
);
   logic [FW-1:0] val_q, nxt_c, low_inc;
   logic          carry_c;

   assign low_inc = bcd_inc({3'b000, val_q[4:0]});

   always_comb begin
      nxt_c   = val_q;
      carry_c = 1'b0;
      if (mode12_i) begin
         if (val_q[4:0] == 5'h12) begin
            nxt_c   = {2'b00, ~val_q[5], 5'h01};
            carry_c = val_q[5];
         end else begin
            nxt_c   = {2'b00, val_q[5], low_inc[4:0]};
         end
      end else begin
         if (val_q == 8'h23) begin
            nxt_c   = 8'h00;
            carry_c = 1'b1;
         end else begin
            nxt_c   = bcd_inc(val_q);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       val_q <= 8'h00;
      else if (load_i)  val_q <= load_val_i;
      else if (step_i)  val_q <= nxt_c;
   end

   assign val_o   = val_q;
   assign carry_o = step_i & carry_c;

   a_r5_pm_flips: assert property (@(posedge clk) disable iff (!rst_n)
      (mode12_i && step_i && !load_i && val_q[4:0] == 5'h12)
      |=> (val_q[5] != $past(val_q[5])) && val_q[4:0] == 5'h01);
   a_r4_midnight: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode12_i && step_i && !load_i && val_q == 8'h23) |=> val_q == 8'h00);
   a_r10_hour_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> val_q == $past(load_val_i));
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
   import rtc_chain_pkg::*;
(
   input  logic [FW-1:0] month_i,
   input  logic [1:0]    leap_i,
   output logic [FW-1:0] last_day_o
);
   always_comb begin
      unique case (month_i)
         8'h02:                      last_day_o = (leap_i == 2'd0) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
         default:                    last_day_o = 8'h31;
      endcase
   end

   always_comb begin
      a_r7_len_range: assert (last_day_o == 8'h28 || last_day_o == 8'h29 ||
                              last_day_o == 8'h30 || last_day_o == 8'h31);
   end
endmodule

// File: rtl/rtc_bcd_chain.sv
module rtc_bcd_chain
   import rtc_chain_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic               run_i,
   input  logic               osc_fail_i,
   input  logic               hour12_i,
   input  logic [NFIELDS-1:0] ld_i,
   input  logic [FW-1:0]      ld_data_i,
   output logic [3:0]         ms_o,
   output logic [FW-1:0]      hund_o,
   output logic [FW-1:0]      sec_o,
   output logic [FW-1:0]      min_o,
   output logic [FW-1:0]      hour_o,
   output logic [FW-1:0]      day_o,
   output logic [FW-1:0]      month_o,
   output logic [FW-1:0]      year_o,
   output logic [FW-1:0]      dow_o,
   output logic [1:0]         leap_o,
   output logic [ROLL_W-1:0]  roll_o
);
   logic adv;
   logic ms_wrap, hund_wrap, sec_wrap, min_wrap, hour_carry;
   logic day_wrap, month_wrap, year_wrap, dow_wrap;
   logic hund_tens, sec_tens;
   logic [FW-1:0] last_day;
   logic [1:0] leap_q;
   logic [ROLL_W-1:0] roll_q;

   // loads win over a coincident tick
   assign adv = tick_i & run_i & ~osc_fail_i & ~(|ld_i);

   rtc_bcd_ctr #(.W(4), .RST_VAL(4'h0)) u_ms (
      .clk, .rst_n, .step_i(adv), .load_i(ld_i[F_MS]), .load_val_i(ld_data_i[3:0]),
      .lo_i(4'h0), .hi_i(4'h9), .val_o(ms_o), .wrap_o(ms_wrap));

   rtc_bcd_ctr #(.W(FW), .RST_VAL(8'h00)) u_hund (
      .clk, .rst_n, .step_i(ms_wrap), .load_i(ld_i[F_HUND]), .load_val_i(ld_data_i),
      .lo_i(8'h00), .hi_i(8'h99), .val_o(hund_o), .wrap_o(hund_wrap));

   rtc_bcd_ctr #(.W(FW), .RST_VAL(8'h00)) u_sec (
      .clk, .rst_n, .step_i(hund_wrap), .load_i(ld_i[F_SEC]), .load_val_i(ld_data_i),
      .lo_i(8'h00), .hi_i(8'h59), .val_o(sec_o), .wrap_o(sec_wrap));

   rtc_bcd_ctr #(.W(FW), .RST_VAL(8'h00)) u_min (
      .clk, .rst_n, .step_i(sec_wrap), .load_i(ld_i[F_MIN]), .load_val_i(ld_data_i),
      .lo_i(8'h00), .hi_i(8'h59), .val_o(min_o), .wrap_o(min_wrap));

   rtc_hour_ctr u_hour (
      .clk, .rst_n, .step_i(min_wrap), .load_i(ld_i[F_HOUR]), .load_val_i(ld_data_i),
      .mode12_i(hour12_i), .val_o(hour_o), .carry_o(hour_carry));

   rtc_month_len u_mlen (.month_i(month_o), .leap_i(leap_q), .last_day_o(last_day));

   rtc_bcd_ctr #(.W(FW), .RST_VAL(8'h01)) u_day (
      .clk, .rst_n, .step_i(hour_carry), .load_i(ld_i[F_DAY]), .load_val_i(ld_data_i),
      .lo_i(8'h01), .hi_i(last_day), .val_o(day_o), .wrap_o(day_wrap));

   rtc_bcd_ctr #(.W(FW), .RST_VAL(8'h01)) u_dow (
      .clk, .rst_n, .step_i(hour_carry), .load_i(ld_i[F_DOW]), .load_val_i(ld_data_i),
      .lo_i(8'h01), .hi_i(8'h07), .val_o(dow_o), .wrap_o(dow_wrap));

   rtc_bcd_ctr #(.W(FW), .RST_VAL(8'h01)) u_month (
      .clk, .rst_n, .step_i(day_wrap), .load_i(ld_i[F_MONTH]), .load_val_i(ld_data_i),
      .lo_i(8'h01), .hi_i(8'h12), .val_o(month_o), .wrap_o(month_wrap));

   rtc_bcd_ctr #(.W(FW), .RST_VAL(8'h00)) u_year (
      .clk, .rst_n, .step_i(month_wrap), .load_i(ld_i[F_YEAR]), .load_val_i(ld_data_i),
      .lo_i(8'h00), .hi_i(8'h99), .val_o(year_o), .wrap_o(year_wrap));

   always_ff @(posedge clk) begin
      if (!rst_n)               leap_q <= 2'd0;
      else if (ld_i[F_LEAP])    leap_q <= ld_data_i[1:0];
      else if (year_wrap)       leap_q <= leap_q + 2'd1;
   end

   assign hund_tens = ms_wrap   & (hund_o[3:0] == 4'h9);
   assign sec_tens  = hund_wrap & (sec_o[3:0]  == 4'h9);

   always_ff @(posedge clk) begin
      if (!rst_n) roll_q <= '0;
      else        roll_q <= {sec_wrap, sec_tens, hund_wrap, hund_tens, ms_wrap, adv};
   end

   assign leap_o = leap_q;
   assign roll_o = roll_q;

   a_r1_blocked_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_fail_i || !run_i) && ld_i == '0 |=> $stable(ms_o) && $stable(hund_o) && roll_o == '0);
   a_r9_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> roll_o[0]);
   a_r10_load_blocks_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_i != '0) |=> roll_o == '0);
   a_r8_leap_step: assert property (@(posedge clk) disable iff (!rst_n)
      (year_wrap && !ld_i[F_LEAP]) |=> leap_q == $past(leap_q) + 2'd1);
   a_r6_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (dow_wrap && !ld_i[F_DOW]) |=> dow_o == 8'h01);
endmodule

// File: tb/rtc_bcd_chain_tb.sv
module rtc_bcd_chain_tb_top;
   import rtc_chain_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_i = 1'b0, run_i = 1'b1, osc_fail_i = 1'b0, hour12_i = 1'b0;
   logic [NFIELDS-1:0] ld_i = '0;
   logic [FW-1:0] ld_data_i = '0;
   logic [3:0] ms_o;
   logic [FW-1:0] hund_o, sec_o, min_o, hour_o, day_o, month_o, year_o, dow_o;
   logic [1:0] leap_o;
   logic [ROLL_W-1:0] roll_o;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   rtc_bcd_chain dut_i (.*);

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic ld(input int idx, input logic [7:0] v);
      @(negedge clk); ld_i = '0; ld_i[idx] = 1'b1; ld_data_i = v;
      @(negedge clk); ld_i = '0;
   endtask

   task automatic tick1();
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
   endtask

   task automatic prime_minute_end();
      ld(F_MS, 8'h09); ld(F_HUND, 8'h99); ld(F_SEC, 8'h59); ld(F_MIN, 8'h59);
   endtask

   task automatic prime_day_end(input logic [7:0] day, input logic [7:0] mon);
      hour12_i = 1'b0;
      prime_minute_end(); ld(F_HOUR, 8'h23); ld(F_DAY, day); ld(F_MONTH, mon);
   endtask

   task automatic t_reset();
      chk("R10 reset ms", {4'h0, ms_o}, 8'h00);
      chk("R10 reset sec", sec_o, 8'h00);
      chk("R10 reset hour", hour_o, 8'h00);
      chk("R7 reset day", day_o, 8'h01);
      chk("R7 reset month", month_o, 8'h01);
      chk("R6 reset dow", dow_o, 8'h01);
      chk("R8 reset leap", {6'd0, leap_o}, 8'h00);
      chk("R9 reset roll", {2'b0, roll_o}, 8'h00);
   endtask

   task automatic t_blocked();
      ld(F_MS, 8'h03);
      run_i = 1'b0; tick1();
      chk("R1 run low ms", {4'h0, ms_o}, 8'h03);
      chk("R1 run low roll", {2'b0, roll_o}, 8'h00);
      run_i = 1'b1; osc_fail_i = 1'b1; tick1();
      chk("R1 osc fail ms", {4'h0, ms_o}, 8'h03);
      osc_fail_i = 1'b0;
   endtask

   task automatic t_subsec();
      ld(F_HUND, 8'h00);
      ld(F_MS, 8'h08); tick1();
      chk("R2 ms 8->9", {4'h0, ms_o}, 8'h09);
      chk("R9 roll 1ms", {2'b0, roll_o}, 8'h01);
      @(negedge clk);
      chk("R9 roll one cycle", {2'b0, roll_o}, 8'h00);
      tick1();
      chk("R2 ms wrap", {4'h0, ms_o}, 8'h00);
      chk("R2 hund step", hund_o, 8'h01);
      chk("R9 roll 10ms", {2'b0, roll_o}, 8'h03);
      ld(F_SEC, 8'h00); ld(F_HUND, 8'h99); ld(F_MS, 8'h09); tick1();
      chk("R2 hund wrap", hund_o, 8'h00);
      chk("R2 sec step", sec_o, 8'h01);
      chk("R9 roll 1s", {2'b0, roll_o}, 8'h0F);
   endtask

   task automatic t_minute();
      hour12_i = 1'b0;
      prime_minute_end(); ld(F_HOUR, 8'h05); tick1();
      chk("R3 sec wrap", sec_o, 8'h00);
      chk("R3 min wrap", min_o, 8'h00);
      chk("R3 hour step", hour_o, 8'h06);
      chk("R9 roll 1min", {2'b0, roll_o}, 8'h3F);
   endtask

   task automatic t_midnight();
      ld(F_DOW, 8'h03);
      prime_day_end(8'h10, 8'h05); tick1();
      chk("R4 hour 23->00", hour_o, 8'h00);
      chk("R4 day step", day_o, 8'h11);
      chk("R6 dow step", dow_o, 8'h04);
      ld(F_DOW, 8'h07);
      prime_day_end(8'h11, 8'h05); tick1();
      chk("R6 dow 7->1", dow_o, 8'h01);
   endtask

   task automatic t_12h();
      hour12_i = 1'b1;
      ld(F_DAY, 8'h05);
      prime_minute_end(); ld(F_HOUR, 8'h12); tick1();
      chk("R5 12AM->01PM", hour_o, 8'h21);
      chk("R5 no day carry", day_o, 8'h05);
      prime_minute_end(); ld(F_HOUR, 8'h09); tick1();
      chk("R5 09->10", hour_o, 8'h10);
      prime_minute_end(); ld(F_HOUR, 8'h32); tick1();
      chk("R5 12PM->01AM", hour_o, 8'h01);
      chk("R5 day carry", day_o, 8'h06);
      hour12_i = 1'b0;
   endtask

   task automatic t_months();
      ld(F_LEAP, 8'h00);
      prime_day_end(8'h28, 8'h02); tick1();
      chk("R7 feb leap0 28->29", day_o, 8'h29);
      prime_day_end(8'h29, 8'h02); tick1();
      chk("R7 feb 29 wrap", day_o, 8'h01);
      chk("R7 feb->mar", month_o, 8'h03);
      ld(F_LEAP, 8'h01);
      prime_day_end(8'h28, 8'h02); tick1();
      chk("R7 feb leap1 wrap", day_o, 8'h01);
      prime_day_end(8'h30, 8'h04); tick1();
      chk("R7 apr 30 wrap", month_o, 8'h05);
      prime_day_end(8'h30, 8'h13); tick1();
      chk("R7 bad month 31", day_o, 8'h31);
      ld(F_YEAR, 8'h24);
      prime_day_end(8'h31, 8'h12); tick1();
      chk("R7 dec wrap month", month_o, 8'h01);
      chk("R7 year step", year_o, 8'h25);
      chk("R8 leap hold", {6'd0, leap_o}, 8'h01);
   endtask

   task automatic t_year();
      ld(F_LEAP, 8'h01); ld(F_YEAR, 8'h99);
      prime_day_end(8'h31, 8'h12); tick1();
      chk("R8 year 99->00", year_o, 8'h00);
      chk("R8 leap 1->2", {6'd0, leap_o}, 8'h02);
      ld(F_LEAP, 8'h03); ld(F_YEAR, 8'h99);
      prime_day_end(8'h31, 8'h12); tick1();
      chk("R8 leap 3->0", {6'd0, leap_o}, 8'h00);
   endtask

   task automatic t_load_prio();
      ld(F_MS, 8'h04);
      @(negedge clk); tick_i = 1'b1; ld_i = '0; ld_i[F_SEC] = 1'b1; ld_data_i = 8'h42;
      @(negedge clk); tick_i = 1'b0; ld_i = '0;
      chk("R10 load lands", sec_o, 8'h42);
      chk("R10 tick dropped ms", {4'h0, ms_o}, 8'h04);
      chk("R10 tick dropped roll", {2'b0, roll_o}, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_blocked();
      t_subsec();
      t_minute();
      t_midnight();
      t_12h();
      t_months();
      t_year();
      t_load_prio();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule